// File: doc/BRIEF.md
# Flag-Setting Add/Subtract Unit

This block is a parameterized two-operand adder/subtractor (32 bits by default). It returns the arithmetic result and four condition flags: negative, zero, carry and overflow. It has four operations: plain add, add with incoming carry, plain subtract, and subtract with incoming carry. For the subtract forms, the carry flag means "no borrow". A processor datapath would feed it operands and the current carry flag, and would use the flags for later conditional decisions.

The result and the freshly computed flags appear combinationally. A small flag register captures the four flags on a rising clock edge, but only while the update enable is high. This gives the surrounding pipeline control over which operations modify the stored condition state.

Top module: `flag_alu`

## Requirements
- R1: The operation select `op_i` chooses the result, modulo 2^WIDTH:
  - 2'b00 gives A+B.
  - 2'b01 gives A+B+cin.
  - 2'b10 gives A-B.
  - 2'b11 gives A-B-1+cin.
- R2: For the add forms, `carry_o` depends on the operation and the incoming carry:
  - For 2'b00, it is set exactly when the result is unsigned-less-than A.
  - For 2'b01 with cin=0, it uses the same test.
  - For 2'b01 with cin=1, it is set when the result is unsigned-less-than-or-equal to A.
- R3: For the subtract forms, `carry_o` is a "no borrow" flag:
  - For 2'b10, it is set when A is unsigned-greater-or-equal to B.
  - For 2'b11 with cin=0, it is set when A is unsigned-greater-than B.
  - For 2'b11 with cin=1, it is set when A is unsigned-greater-or-equal to B.
- R4: For the add forms, `ovf_o` is set when A and B have equal sign bits and the result's sign bit differs from A's. This is the case where the exact signed sum does not fit in WIDTH bits.
- R5: For the subtract forms, `ovf_o` is set when A and B have different sign bits and the result's sign bit differs from A's. This is the case where the exact signed difference does not fit in WIDTH bits.
- R6: `neg_o` equals the most significant result bit, and `zero_o` is set exactly when the result is all zeros.
- R7: `cin_i` has no effect on the result or the flags when `op_i[0]` is 0.
- R8: On a rising edge with `flag_we_i` high, `flags_q_o` loads {N,Z,C,V}, with N in bit 3, Z in bit 2, C in bit 1 and V in bit 0. With `flag_we_i` low, `flags_q_o` keeps its value.
- R9: While `rst_n` is low, `flags_q_o` is cleared to 4'b0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Active-low reset of the flag register |
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| op_i | input | 2 | Operation select |
| cin_i | input | 1 | Incoming carry flag |
| flag_we_i | input | 1 | Flag register update enable |
| res_o | output | WIDTH | Arithmetic result |
| neg_o | output | 1 | Negative flag of the current operation |
| zero_o | output | 1 | Zero flag of the current operation |
| carry_o | output | 1 | Carry / no-borrow flag of the current operation |
| ovf_o | output | 1 | Signed overflow flag of the current operation |
| flags_q_o | output | 4 | Stored flags {N,Z,C,V} |

## Verification
The hardest corner is the with-carry forms where the carry-in makes the wrap exact:
- add-with-carry of an all-ones operand plus carry-in, whose result equals A, so carry must be set;
- subtract-with-carry of equal operands, where carry-in 0 must borrow and carry-in 1 must not.

A full sweep over a 4-bit instance reaches these corners without targeting. It covers every operand pair, every operation and both carry-in values, and compares each result with an independent model built from unsigned comparisons and exact signed ranges. A 32-bit instance then repeats the sign-boundary and wrap cases directly.

// File: rtl/flag_alu.sv
module flag_alu #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       op_i,
  input  logic             cin_i,
  input  logic             flag_we_i,
  output logic [WIDTH-1:0] res_o,
  output logic             neg_o,
  output logic             zero_o,
  output logic             carry_o,
  output logic             ovf_o,
  output logic [3:0]       flags_q_o
);
  localparam int MSB = WIDTH - 1;

  logic             is_sub;
  logic             carry_in;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   sum;
  logic [WIDTH-1:0] sign_mix;

  assign is_sub   = op_i[1];
  assign b_eff    = is_sub ? ~b_i : b_i;
  assign carry_in = op_i[0] ? cin_i : is_sub;
  assign sum      = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, carry_in};

  assign res_o    = sum[MSB:0];
  assign carry_o  = sum[WIDTH];
  assign neg_o    = sum[MSB];
  assign zero_o   = (sum[MSB:0] == '0);

  assign sign_mix = is_sub ? (a_i ^ b_i) : ~(a_i ^ b_i);
  assign ovf_o    = sign_mix[MSB] & (a_i[MSB] ^ sum[MSB]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flags_q_o <= 4'b0000;
    else if (flag_we_i)
      flags_q_o <= {neg_o, zero_o, carry_o, ovf_o};
  end
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [1:0]       op_i,
  input logic             flag_we_i,
  input logic [WIDTH-1:0] res_o,
  input logic             neg_o,
  input logic             zero_o,
  input logic             carry_o,
  input logic             ovf_o,
  input logic [3:0]       flags_q_o
);
  localparam int MSB = WIDTH - 1;

  AST_ADD_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 2'b00) |-> (carry_o == (res_o < a_i))); // R2
  AST_SUB_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 2'b10) |-> (carry_o == (a_i >= b_i))); // R3
  AST_ADD_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_i[1] && (a_i[MSB] != b_i[MSB])) |-> !ovf_o); // R4
  AST_SUB_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i[1] && (a_i[MSB] == b_i[MSB])) |-> !ovf_o); // R5
  AST_ZERO_NOT_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    zero_o |-> !neg_o); // R6
  AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we_i |=> (flags_q_o == $past({neg_o, zero_o, carry_o, ovf_o}))); // R8
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we_i |=> $stable(flags_q_o)); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> (flags_q_o == 4'b0000)); // R9
endmodule

bind flag_alu flag_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_i(a_i), .b_i(b_i), .op_i(op_i),
  .flag_we_i(flag_we_i), .res_o(res_o), .neg_o(neg_o), .zero_o(zero_o),
  .carry_o(carry_o), .ovf_o(ovf_o), .flags_q_o(flags_q_o)
);

// File: tb/flag_alu_tb.sv
`timescale 1ns/1ps
module flag_alu_tb;
  logic clk = 1'b0;
  logic rst_n;
  always #10 clk = ~clk;

  logic [3:0]  a4, b4, r4, fq4;
  logic [31:0] a32, b32, r32;
  logic [3:0]  fq32;
  logic [1:0]  op;
  logic        cin, we;
  logic        n4, z4, c4, v4, n32, z32, c32, v32;

  int tests = 0;
  int fails = 0;

  flag_alu #(.WIDTH(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .a_i(a4), .b_i(b4), .op_i(op), .cin_i(cin),
    .flag_we_i(we), .res_o(r4), .neg_o(n4), .zero_o(z4), .carry_o(c4),
    .ovf_o(v4), .flags_q_o(fq4));

  flag_alu #(.WIDTH(32)) u_dut_w32 (
    .clk(clk), .rst_n(rst_n), .a_i(a32), .b_i(b32), .op_i(op), .cin_i(cin),
    .flag_we_i(we), .res_o(r32), .neg_o(n32), .zero_o(z32), .carry_o(c32),
    .ovf_o(v32), .flags_q_o(fq32));

  function automatic void model(input int w, input longint ua, input longint ub,
                                input logic [1:0] o, input logic ci,
                                output longint res, output logic [3:0] nzcv);
    longint m, half, sa, sb, exact;
    logic c, v;
    m    = (longint'(1) << w) - 1;
    half = longint'(1) << (w - 1);
    sa   = (ua >= half) ? ua - 2 * half : ua;
    sb   = (ub >= half) ? ub - 2 * half : ub;
    case (o)
      2'b00: begin exact = sa + sb;          res = (ua + ub) & m;          c = res < ua; end
      2'b01: begin exact = sa + sb + ci;     res = (ua + ub + ci) & m;     c = ci ? (res <= ua) : (res < ua); end
      2'b10: begin exact = sa - sb;          res = (ua - ub) & m;          c = ua >= ub; end
      default: begin exact = sa - sb - 1 + ci; res = (ua - ub - 1 + ci) & m; c = ci ? (ua >= ub) : (ua > ub); end
    endcase
    v = (exact < -half) || (exact > half - 1);
    nzcv = {res >= half, res == 0, c, v};
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s op=%0d cin=%0d actual=%0h expected=%0h", tag, op, cin, act, exp);
    end
  endtask

  initial begin
    #(20ns * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    longint er;
    logic [3:0] ef, held;
    rst_n = 1'b0; a4 = '0; b4 = '0; a32 = '0; b32 = '0; op = '0; cin = 1'b0; we = 1'b1;
    repeat (2) @(negedge clk);
    check(fq4 == 4'b0000, "R9 reset w4", fq4, 0);
    check(fq32 == 4'b0000, "R9 reset w32", fq32, 0);
    rst_n = 1'b1;

    for (int o = 0; o < 4; o++)
      for (int ci = 0; ci < 2; ci++)
        for (int a = 0; a < 16; a++)
          for (int b = 0; b < 16; b++) begin
            op = o[1:0]; cin = ci[0]; a4 = a[3:0]; b4 = b[3:0]; we = 1'b1;
            #1;
            model(4, a, b, op, cin, er, ef);
            check(r4 == er[3:0], op[0] ? "R1 result" : "R1/R7 result", r4, er);
            check({n4, z4} == ef[3:2], "R6 neg/zero", {n4, z4}, ef[3:2]);
            check(c4 == ef[1], op[1] ? "R3 carry" : "R2 carry", c4, ef[1]);
            check(v4 == ef[0], op[1] ? "R5 overflow" : "R4 overflow", v4, ef[0]);
            @(negedge clk);
            check(fq4 == ef, "R8 load", fq4, ef);
          end

    held = fq4;
    op = 2'b10; cin = 1'b0; a4 = 4'h0; b4 = 4'h1; we = 1'b0;
    @(negedge clk);
    check(fq4 == held, "R8 hold", fq4, held);

    for (int k = 0; k < 8; k++) begin
      longint va, vb;
      case (k)
        0: begin va = 64'h7FFFFFFF; vb = 1;            op = 2'b00; cin = 1'b1; end
        1: begin va = 64'hFFFFFFFF; vb = 1;            op = 2'b00; cin = 1'b0; end
        2: begin va = 64'h80000000; vb = 1;            op = 2'b10; cin = 1'b1; end
        3: begin va = 0;            vb = 0;            op = 2'b10; cin = 1'b0; end
        4: begin va = 0;            vb = 0;            op = 2'b11; cin = 1'b0; end
        5: begin va = 64'h12345678; vb = 64'h12345678; op = 2'b11; cin = 1'b1; end
        6: begin va = 64'hFFFFFFFF; vb = 0;            op = 2'b01; cin = 1'b1; end
        default: begin va = 64'h80000000; vb = 64'h80000000; op = 2'b01; cin = 1'b0; end
      endcase
      a32 = va[31:0]; b32 = vb[31:0]; we = 1'b1;
      #1;
      model(32, va, vb, op, cin, er, ef);
      check(r32 == er[31:0], "R1 w32 result", r32, er);
      check({n32, z32, c32, v32} == ef, op[1] ? "R3/R5 w32 flags" : "R2/R4 w32 flags", {n32, z32, c32, v32}, ef);
      @(negedge clk);
      check(fq32 == ef, "R8 w32 load", fq32, ef);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule